// File: doc/BRIEF.md
# Posted-Write Flush Handshake Controller

This controller sits in a bridge between PCI and a slower expansion bus. It decides when the bridge may hand the expansion bus to the system controller. Before an expansion-bus master or DMA engine is allowed onto that bus, it makes sure that every posted write buffer aimed at PCI has been disabled and emptied. When the system controller asks for the bus, the bridge finishes the cycle already in progress and refuses new ones. It then floats its expansion-bus drivers and, once it is no longer locked as a PCI resource, grants the bus.

Whether a flush is needed is decided only after the grant. If the system controller keeps the flush-control line low, the ownership is a refresh: no flush is requested, and the controller waits for the hold request to go away. If the line goes high, the controller raises a flush-toward-PCI request and waits for the wire-ORed memory acknowledge. It then drives the flush-control line back to the system controller to report that all buffers are empty. The flush request stays up until the hold request is withdrawn.

Two further requests share the active-low request pair and are taken from synchronous inputs: a flush toward main memory, and guaranteed immediate PCI access to main memory. All control pins are plain levels. The block has no streaming data path, so there is no valid/ready interface.

Top module: `pwf_handshake_ctrl`

## Requirements
- R1: The pair {flush_req_n_o, mem_req_n_o} encodes 2'b11 as idle, 2'b01 as flush toward PCI, 2'b10 as flush toward main memory, and 2'b00 as guaranteed PCI access to main memory.
- R2: When hold_req_i rises, new_cyc_inhibit_o rises 3 cycles later. Once cyc_busy_i and locked_i are both low, bus_float_o rises on the next cycle and hold_ack_o on the cycle after that. hold_ack_o is never high without bus_float_o and new_cyc_inhibit_o.
- R3: hold_ack_o never rises while locked_i was high at the preceding clock edge. The grant waits for the lock to clear.
- R4: If flush_ctl_i stays low after the grant, the outputs never show the flush-toward-PCI code and flush_done_o stays low until the hold is released.
- R5: While granted, flush_ctl_i high and mem_ack_i low produce the flush-toward-PCI code 3 cycles after flush_ctl_i rises. That code is never shown without hold_ack_o.
- R6: While the flush-toward-PCI code is shown, mem_ack_i high raises flush_done_o 3 cycles later. flush_done_o is never high unless hold_ack_o is high and the PCI flush code is shown.
- R7: The flush-toward-PCI code holds for the whole ownership and is removed on the same edge on which hold_ack_o falls.
- R8: A new flush-toward-PCI request is not raised while the synchronized mem_ack_i is still high. It is raised 3 cycles after mem_ack_i goes low.
- R9: 3 cycles after hold_req_i falls, hold_ack_o, flush_done_o, new_cyc_inhibit_o and bus_float_o all drop on the same edge.
- R10: While rst is high at a clock edge, the outputs become: request pair 2'b11, and hold_ack_o, flush_done_o, new_cyc_inhibit_o and bus_float_o all low.
- R11: gat_req_i and mem_flush_req_i take effect on the outputs one cycle after they change. Priority runs from flush toward PCI, then guaranteed access (gat_req_i), then flush toward memory (mem_flush_req_i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hold_req_i | input | 1 | Asynchronous bus hold request from the system controller |
| flush_ctl_i | input | 1 | Asynchronous flush-control level from the system controller (high: flush needed) |
| mem_ack_i | input | 1 | Asynchronous wire-ORed acknowledge that buffers are flushed |
| cyc_busy_i | input | 1 | Synchronous: a bridge cycle is still in progress |
| locked_i | input | 1 | Synchronous: the bridge is locked as a PCI resource |
| gat_req_i | input | 1 | Synchronous request for guaranteed PCI access to memory |
| mem_flush_req_i | input | 1 | Synchronous request to flush buffers toward main memory |
| hold_ack_o | output | 1 | Expansion bus granted to the system controller |
| new_cyc_inhibit_o | output | 1 | Refuse new bridge cycles |
| bus_float_o | output | 1 | Float the bridge's expansion-bus drivers |
| flush_req_n_o | output | 1 | Active-low flush request (see R1) |
| mem_req_n_o | output | 1 | Active-low memory request (see R1) |
| flush_done_o | output | 1 | Drive the flush-control line asserted: all buffers flushed |

## Verification
A wrong state register shows up at the ports as a combination that cannot occur: a grant without float, a PCI flush code without a grant, or a flush-done drive outside ownership. Each of these shows on the edge where the bad state is entered. A stuck or skipped state instead shows as a latency mismatch. The bench counts the cycles from each input change to the expected 3-cycle (synchronized) or 1-cycle (registered) response, so a missing or extra stage is caught within a handful of cycles. A controller that forgets the acknowledge gate raises its flush request while mem_ack_i is still held high. That is visible as soon as the gate's 3-cycle window ends.

// File: rtl/pwf_pkg.sv
package pwf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DRAIN  = 3'd1,
    ST_FLOAT  = 3'd2,
    ST_DECIDE = 3'd3,
    ST_FLUSH  = 3'd4,
    ST_OWNED  = 3'd5
  } pwf_state_e;

  // {flush_req_n, mem_req_n}
  typedef enum logic [1:0] {
    REQ_GAT  = 2'b00,
    REQ_PCI  = 2'b01,
    REQ_MEM  = 2'b10,
    REQ_IDLE = 2'b11
  } pwf_req_e;

  localparam int unsigned ASYNC_W = 3;
  localparam int unsigned IDX_HOLD  = 0;
  localparam int unsigned IDX_FLUSH = 1;
  localparam int unsigned IDX_ACK   = 2;

endpackage

// File: rtl/pwf_sync.sv
module pwf_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= async_i;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign sync_o = stage_q[LAST];

endmodule

// File: rtl/pwf_fsm.sv
module pwf_fsm
  import pwf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hold_s,
  input  logic flush_s,
  input  logic ack_s,
  input  logic busy,
  input  logic locked,
  output logic hold_ack,
  output logic float_en,
  output logic inhibit,
  output logic pci_flush,
  output logic done_drv
);

  pwf_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (hold_s) state_d = ST_DRAIN;
      ST_DRAIN: begin
        if (!hold_s)               state_d = ST_IDLE;
        else if (!busy && !locked) state_d = ST_FLOAT;
      end
      ST_FLOAT: begin
        if (!hold_s)      state_d = ST_IDLE;
        else if (!locked) state_d = ST_DECIDE;
      end
      ST_DECIDE: begin
        if (!hold_s)                state_d = ST_IDLE;
        else if (flush_s && !ack_s) state_d = ST_FLUSH;
      end
      ST_FLUSH: begin
        if (!hold_s)    state_d = ST_IDLE;
        else if (ack_s) state_d = ST_OWNED;
      end
      ST_OWNED:  if (!hold_s) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  always_comb begin
    hold_ack  = (state_q == ST_DECIDE) || (state_q == ST_FLUSH) || (state_q == ST_OWNED);
    float_en  = hold_ack || (state_q == ST_FLOAT);
    inhibit   = (state_q != ST_IDLE);
    pci_flush = (state_q == ST_FLUSH) || (state_q == ST_OWNED);
    done_drv  = (state_q == ST_OWNED);
  end

endmodule

// File: rtl/pwf_req_enc.sv
module pwf_req_enc
  import pwf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pci_flush,
  input  logic gat_req,
  input  logic mem_req,
  output logic flush_req_n,
  output logic mem_req_n
);

  logic     gat_q, mem_q;
  pwf_req_e code;

  always_ff @(posedge clk) begin
    if (rst) begin
      gat_q <= 1'b0;
      mem_q <= 1'b0;
    end else begin
      gat_q <= gat_req;
      mem_q <= mem_req;
    end
  end

  always_comb begin
    if (pci_flush)  code = REQ_PCI;
    else if (gat_q) code = REQ_GAT;
    else if (mem_q) code = REQ_MEM;
    else            code = REQ_IDLE;
  end

  assign flush_req_n = code[1];
  assign mem_req_n   = code[0];

endmodule

// File: rtl/pwf_handshake_ctrl.sv
module pwf_handshake_ctrl
  import pwf_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_req_i,
  input  logic flush_ctl_i,
  input  logic mem_ack_i,
  input  logic cyc_busy_i,
  input  logic locked_i,
  input  logic gat_req_i,
  input  logic mem_flush_req_i,
  output logic hold_ack_o,
  output logic new_cyc_inhibit_o,
  output logic bus_float_o,
  output logic flush_req_n_o,
  output logic mem_req_n_o,
  output logic flush_done_o
);

  logic [ASYNC_W-1:0] async_vec, sync_vec;
  logic hold_s, flush_s, ack_s, pci_flush;

  assign async_vec[IDX_HOLD]  = hold_req_i;
  assign async_vec[IDX_FLUSH] = flush_ctl_i;
  assign async_vec[IDX_ACK]   = mem_ack_i;

  pwf_sync #(.WIDTH(ASYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (async_vec),
    .sync_o  (sync_vec)
  );

  assign hold_s  = sync_vec[IDX_HOLD];
  assign flush_s = sync_vec[IDX_FLUSH];
  assign ack_s   = sync_vec[IDX_ACK];

  pwf_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .hold_s    (hold_s),
    .flush_s   (flush_s),
    .ack_s     (ack_s),
    .busy      (cyc_busy_i),
    .locked    (locked_i),
    .hold_ack  (hold_ack_o),
    .float_en  (bus_float_o),
    .inhibit   (new_cyc_inhibit_o),
    .pci_flush (pci_flush),
    .done_drv  (flush_done_o)
  );

  pwf_req_enc u_enc (
    .clk         (clk),
    .rst         (rst),
    .pci_flush   (pci_flush),
    .gat_req     (gat_req_i),
    .mem_req     (mem_flush_req_i),
    .flush_req_n (flush_req_n_o),
    .mem_req_n   (mem_req_n_o)
  );

endmodule

// File: rtl/pwf_checker.sv
module pwf_checker (
  input logic clk,
  input logic rst,
  input logic locked_i,
  input logic hold_ack_o,
  input logic bus_float_o,
  input logic new_cyc_inhibit_o,
  input logic flush_done_o,
  input logic flush_req_n_o,
  input logic mem_req_n_o,
  input logic pci_flush,
  input logic ack_s
);

  AST_GRANT_FLOATS: assert property (@(posedge clk) disable iff (rst)
    hold_ack_o |-> (bus_float_o && new_cyc_inhibit_o)); // R2

  AST_NO_GRANT_LOCKED: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack_o) |-> !$past(locked_i)); // R3

  AST_PCI_CODE_GRANTED: assert property (@(posedge clk) disable iff (rst)
    (!flush_req_n_o && mem_req_n_o) |-> hold_ack_o); // R5

  AST_DONE_IN_OWNERSHIP: assert property (@(posedge clk) disable iff (rst)
    flush_done_o |-> (hold_ack_o && !flush_req_n_o && mem_req_n_o)); // R6

  AST_ACK_LOW_BEFORE_FLUSH: assert property (@(posedge clk) disable iff (rst)
    $rose(pci_flush) |-> !$past(ack_s)); // R8

  AST_RELEASE_ONE_EDGE: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_ack_o) |-> (!flush_done_o && !new_cyc_inhibit_o && !bus_float_o)); // R9

  AST_RELEASE_DROPS_PCI: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_ack_o) |-> !(!flush_req_n_o && mem_req_n_o)); // R7

endmodule

bind pwf_handshake_ctrl pwf_checker u_chk (
  .clk               (clk),
  .rst               (rst),
  .locked_i          (locked_i),
  .hold_ack_o        (hold_ack_o),
  .bus_float_o       (bus_float_o),
  .new_cyc_inhibit_o (new_cyc_inhibit_o),
  .flush_done_o      (flush_done_o),
  .flush_req_n_o     (flush_req_n_o),
  .mem_req_n_o       (mem_req_n_o),
  .pci_flush         (pci_flush),
  .ack_s             (ack_s)
);

// File: tb/sim_pwf_handshake_ctrl.sv
module sim_pwf_handshake_ctrl;

  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold_req_i = 0, flush_ctl_i = 0, mem_ack_i = 0;
  logic cyc_busy_i = 0, locked_i = 0, gat_req_i = 0, mem_flush_req_i = 0;
  logic hold_ack_o, new_cyc_inhibit_o, bus_float_o;
  logic flush_req_n_o, mem_req_n_o, flush_done_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwf_handshake_ctrl u0 (
    .clk(clk), .rst(rst),
    .hold_req_i(hold_req_i), .flush_ctl_i(flush_ctl_i), .mem_ack_i(mem_ack_i),
    .cyc_busy_i(cyc_busy_i), .locked_i(locked_i),
    .gat_req_i(gat_req_i), .mem_flush_req_i(mem_flush_req_i),
    .hold_ack_o(hold_ack_o), .new_cyc_inhibit_o(new_cyc_inhibit_o),
    .bus_float_o(bus_float_o), .flush_req_n_o(flush_req_n_o),
    .mem_req_n_o(mem_req_n_o), .flush_done_o(flush_done_o)
  );

  function automatic logic [1:0] exp_code(input bit pci, input bit gat, input bit mem);
    if (pci)      return 2'b01;
    else if (gat) return 2'b00;
    else if (mem) return 2'b10;
    else          return 2'b11;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int code();
    return int'({flush_req_n_o, mem_req_n_o});
  endfunction

  // One hold episode: blocked for x cycles by busy or lock, then refresh or flush.
  task automatic episode(input int x, input bit use_lock, input bit do_flush);
    if (use_lock) locked_i = 1; else cyc_busy_i = 1;
    hold_req_i = 1;
    step(2);
    chk("R2 inhibit not yet", new_cyc_inhibit_o, 0);
    step(1);
    chk("R2 inhibit after 3", new_cyc_inhibit_o, 1);
    for (int i = 0; i < x; i++) begin
      step(1);
      chk(use_lock ? "R3 no grant while locked" : "R2 no float while busy",
          int'({bus_float_o, hold_ack_o}), 0);
    end
    cyc_busy_i = 0; locked_i = 0;
    step(1);
    chk("R2 float before grant", int'({bus_float_o, hold_ack_o}), 2);
    step(1);
    chk("R2 grant", int'({bus_float_o, hold_ack_o, new_cyc_inhibit_o}), 7);
    if (do_flush) begin
      flush_ctl_i = 1;
      step(2);
      chk("R5 no flush code yet", code(), 3);
      step(1);
      chk("R5 R1 PCI flush code", code(), 1);
      mem_ack_i = 1;
      step(2);
      chk("R6 not driven yet", flush_done_o, 0);
      step(1);
      chk("R6 flush done driven", flush_done_o, 1);
      step(3);
      chk("R7 code held in ownership", code(), 1);
    end else begin
      step(5);
      chk("R4 refresh no flush code", code(), 3);
      chk("R4 refresh no done", flush_done_o, 0);
    end
    hold_req_i = 0;
    step(2);
    chk("R9 grant still up", hold_ack_o, 1);
    step(1);
    chk("R9 release together",
        int'({hold_ack_o, flush_done_o, new_cyc_inhibit_o, bus_float_o}), 0);
    chk("R7 code removed with grant", code(), 3);
    flush_ctl_i = 0; mem_ack_i = 0;
    step(3);
  endtask

  initial begin
    int seed = 32'h5eed_0042;
    void'($urandom(seed));
    step(4);
    chk("R10 reset request pair", code(), 3);
    chk("R10 reset controls",
        int'({hold_ack_o, flush_done_o, new_cyc_inhibit_o, bus_float_o}), 0);
    rst = 0;
    step(2);
    chk("R10 idle after reset", code(), 3);

    // Directed episodes
    episode(0, 0, 1);
    episode(4, 1, 0);
    episode(3, 0, 0);

    // R8: acknowledge still high from the previous flush
    episode(0, 0, 1);
    hold_req_i = 1; mem_ack_i = 1;
    step(5);
    chk("R2 R8 regrant", hold_ack_o, 1);
    flush_ctl_i = 1;
    step(6);
    chk("R8 flush held off while ack high", code(), 3);
    mem_ack_i = 0;
    step(2);
    chk("R8 still held off in sync window", code(), 3);
    step(1);
    chk("R8 flush after ack low", code(), 1);
    hold_req_i = 0; flush_ctl_i = 0;
    step(3);
    chk("R9 release after R8", hold_ack_o, 0);
    step(2);

    // R11: mode requests and priority, directed
    gat_req_i = 1; mem_flush_req_i = 1;
    chk("R11 no change before edge", code(), 3);
    step(1);
    chk("R11 R1 guaranteed access wins over memory", code(), 0);
    gat_req_i = 0;
    step(1);
    chk("R11 R1 memory flush code", code(), 2);
    hold_req_i = 1; flush_ctl_i = 1;
    step(8);
    chk("R11 PCI flush wins", code(), 1);
    hold_req_i = 0; flush_ctl_i = 0; mem_flush_req_i = 0;
    step(3);
    chk("R11 back to idle", code(), 3);
    step(3);

    // Random mode requests while idle
    for (int i = 0; i < 200; i++) begin
      gat_req_i = 1'($urandom);
      mem_flush_req_i = 1'($urandom);
      step(1);
      chk("R11 random mode code", code(), int'(exp_code(0, gat_req_i, mem_flush_req_i)));
    end
    gat_req_i = 0; mem_flush_req_i = 0;
    step(1);

    // Random episodes
    for (int i = 0; i < 30; i++) begin
      episode(int'($urandom_range(0, 5)), 1'($urandom), 1'($urandom));
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule